// File: doc/BRIEF.md
# Command-to-Data Delay Aligner

This block sits between the capture side of a DRAM read path and an outbound serial link. A read command is marked by a one-cycle pulse on `cmd_valid`, and that pulse starts a countdown. One clock cycle stands for one unit interval (UI). A frame is 12 UI. The delay from command to data is set by three inputs: a whole number of frames, a sub-frame fraction in UI, and an extra stretch given in whole frames. Read beats may arrive early and at irregular times. They are kept in a FIFO in arrival order. When a countdown expires, the oldest beat is released on the link side for exactly one cycle.

The block also holds a separate combinational helper. It turns a raw delay in UI into a frame-and-fraction pair, rounding to the sub-frame granularity the user selects. Its output is meant to fill in the delay settings. For a raw delay of 29 UI it gives 2 frames + 5 UI at 1 UI steps, 2 frames + 6 UI at 2 UI steps, and 3 frames + 0 UI when only whole frames are allowed.

Two errors are latched and stay set until reset: a launch that finds no buffered data (underrun), and a beat that arrives while the buffer is full (overflow). The reset input is asynchronous and active-low, and its release is synchronised inside the block. Nothing issued in the first three cycles after release is guaranteed to be accepted.

Top module: `c2d_aligner`

## Requirements
- R1: While `rst_n` is low, `data_out_valid`, `err_underrun` and `err_overflow` are 0. After reset, the buffer is empty and no countdown is running, so a command issued after release finds no data from before the reset.
- R2: With `gran_mode` = 0 (1 UI steps), `rnd_frames` = raw_ui / 12 and `rnd_frac` = raw_ui mod 12. In every mode `rnd_frac` is below 12.
- R3: With `gran_mode` = 1 (2 UI steps), an odd remainder is raised to the next even value. When the remainder is 11 it becomes 0 and `rnd_frames` grows by one. An even remainder is passed unchanged.
- R4: With `gran_mode` = 2 or 3 (whole frames only), any nonzero remainder raises `rnd_frames` by one, and `rnd_frac` is always 0.
- R5: A command accepted in cycle c with `cfg_extra` = 0 makes `data_out_valid` high in cycle c + D and in no other cycle. Here D = 12·`cfg_frames` + `cfg_frac`, with no cycle added.
- R6: A nonzero `cfg_extra` moves the launch cycle later by 12·`cfg_extra` cycles.
- R7: A beat captured before its launch cycle is held. This includes a beat captured in the cycle just before launch. Each launch presents the oldest held beat on `data_out`, so beats leave in arrival order.
- R8: Up to 4 commands can be outstanding. A command stays outstanding up to and including its launch cycle. A command that arrives while 4 are outstanding is ignored and produces no launch.
- R9: A launch that finds the buffer empty produces no `data_out_valid`, retires the command, and sets `err_underrun` from the next cycle until reset.
- R10: The buffer holds 16 beats. A beat that arrives while 16 are held is dropped, even if a launch happens in the same cycle. It sets `err_overflow` from the next cycle until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per UI |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle pulse marking a read command |
| cfg_frames | input | 4 | Delay in whole frames |
| cfg_frac | input | 4 | Sub-frame part of the delay in UI, 0 to 11 |
| cfg_extra | input | 2 | Additional delay in whole frames |
| data_in_valid | input | 1 | A read beat is present on `data_in` |
| data_in | input | 16 | Read beat from the capture path |
| data_out_valid | output | 1 | A beat is launched this cycle |
| data_out | output | 16 | Launched beat (oldest held) |
| err_underrun | output | 1 | Sticky: a launch found no data |
| err_overflow | output | 1 | Sticky: a beat arrived with the buffer full |
| raw_ui | input | 8 | Raw delay in UI for the rounding helper |
| gran_mode | input | 2 | 0: 1 UI steps, 1: 2 UI steps, 2 or 3: whole frames only |
| rnd_frames | output | 5 | Rounded frame count |
| rnd_frac | output | 4 | Rounded fraction in UI |

## Verification
The checker relies on the stimulus keeping to four conditions:
- The total delay D is at least 1.
- `cfg_frac` stays below 12.
- The delay settings are constant while any command is outstanding.
- `cmd_valid` is never high in two commands' worth of the same cycle.

Under these conditions two countdowns can never expire in the same cycle, and the single-launch property depends on that. The bench changes the delay settings only right after a reset, when nothing is outstanding, and it never uses the all-zero delay. It issues commands only from the third idle cycle after reset release onwards.

// File: rtl/c2d_pkg.sv
package c2d_pkg;

  // Unit intervals per link frame; one clock cycle per UI.
  localparam int FRAME_UI = 12;
  localparam int FRAC_W   = $clog2(FRAME_UI);

  typedef enum logic [1:0] {
    GRAN_UI1     = 2'd0,
    GRAN_UI2     = 2'd1,
    GRAN_FRAME   = 2'd2,
    GRAN_FRAME_B = 2'd3
  } gran_e;

endpackage

// File: rtl/c2d_rst_sync.sv
module c2d_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic meta;

  // Assert at once, release after two rising edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta    <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      meta    <= 1'b1;
      rst_n_s <= meta;
    end
  end

endmodule

// File: rtl/c2d_round.sv
module c2d_round
  import c2d_pkg::*;
#(
  parameter int RAW_W  = 8,
  parameter int OFRM_W = 5
) (
  input  logic [RAW_W-1:0]  raw_ui,
  input  logic [1:0]        gran_mode,
  output logic [OFRM_W-1:0] frames,
  output logic [FRAC_W-1:0] frac
);

  logic [RAW_W-1:0]  quo;
  logic [RAW_W-1:0]  rem;
  logic [OFRM_W-1:0] base_f;
  logic [FRAC_W-1:0] base_r;
  gran_e             mode;

  always_comb begin
    quo    = raw_ui / RAW_W'(FRAME_UI);
    rem    = raw_ui % RAW_W'(FRAME_UI);
    base_f = OFRM_W'(quo);
    base_r = FRAC_W'(rem);
    mode   = gran_e'(gran_mode);
    frames = base_f;
    frac   = base_r;
    case (mode)
      GRAN_UI1: begin
      end
      GRAN_UI2: begin
        if (base_r[0]) begin
          if (base_r == FRAC_W'(FRAME_UI - 1)) begin
            frames = base_f + OFRM_W'(1);
            frac   = '0;
          end else begin
            frac = base_r + FRAC_W'(1);
          end
        end
      end
      default: begin
        if (base_r != '0) begin
          frames = base_f + OFRM_W'(1);
        end
        frac = '0;
      end
    endcase
  end

endmodule

// File: rtl/c2d_slot.sv
module c2d_slot #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             fire
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    busy    = (cnt != '0);
    fire    = (cnt == CNT_W'(1));
    cnt_en  = load | busy;
    cnt_nxt = load ? load_val : (cnt - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/c2d_fifo.sv
module c2d_fifo #(
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 16,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              empty,
  output logic [AW:0]       count
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;
  logic [AW-1:0]     wr_nxt;
  logic [AW-1:0]     rd_nxt;
  logic [AW:0]       cnt_nxt;

  always_comb begin
    wr_nxt  = wr_ptr + AW'(1);
    rd_nxt  = rd_ptr + AW'(1);
    cnt_nxt = count + (AW+1)'(push) - (AW+1)'(pop);
    full    = (count == (AW+1)'(DEPTH));
    empty   = (count == '0);
    rdata   = mem[rd_ptr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)        wr_ptr <= wr_nxt;
      if (pop)         rd_ptr <= rd_nxt;
      if (push || pop) count  <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

endmodule

// File: rtl/c2d_aligner.sv
module c2d_aligner
  import c2d_pkg::*;
#(
  parameter  int DATA_W     = 16,
  parameter  int FIFO_DEPTH = 16,
  parameter  int MAX_OUT    = 4,
  parameter  int FRM_W      = 4,
  parameter  int XTR_W      = 2,
  parameter  int RAW_W      = 8,
  localparam int RFRM_W     = $clog2((2**RAW_W - 1) / FRAME_UI + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [FRM_W-1:0]  cfg_frames,
  input  logic [FRAC_W-1:0] cfg_frac,
  input  logic [XTR_W-1:0]  cfg_extra,
  input  logic              data_in_valid,
  input  logic [DATA_W-1:0] data_in,
  output logic              data_out_valid,
  output logic [DATA_W-1:0] data_out,
  output logic              err_underrun,
  output logic              err_overflow,
  input  logic [RAW_W-1:0]  raw_ui,
  input  logic [1:0]        gran_mode,
  output logic [RFRM_W-1:0] rnd_frames,
  output logic [FRAC_W-1:0] rnd_frac
);

  localparam int DLY_MAX = (2**FRM_W - 1) * FRAME_UI + (FRAME_UI - 1)
                         + (2**XTR_W - 1) * FRAME_UI;
  localparam int CNT_W   = $clog2(DLY_MAX + 1);
  localparam int FAW     = $clog2(FIFO_DEPTH);

  logic                rst_n_s;
  logic [CNT_W-1:0]    launch_dly;
  logic [MAX_OUT-1:0]  slot_busy;
  logic [MAX_OUT-1:0]  slot_load;
  logic [MAX_OUT-1:0]  slot_fire;
  logic                sel_done;
  logic                fire_any;
  logic                fifo_push;
  logic                fifo_pop;
  logic                fifo_full;
  logic                fifo_empty;
  logic [FAW:0]        fifo_cnt;
  logic                und_set;
  logic                ovf_set;

  c2d_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  c2d_round #(.RAW_W(RAW_W), .OFRM_W(RFRM_W)) i_round (
    .raw_ui    (raw_ui),
    .gran_mode (gran_mode),
    .frames    (rnd_frames),
    .frac      (rnd_frac)
  );

  // Launch delay in cycles: frames and extra frames at 12 UI each, plus fraction.
  always_comb begin
    launch_dly = CNT_W'(cfg_frames) * CNT_W'(FRAME_UI)
               + CNT_W'(cfg_frac)
               + CNT_W'(cfg_extra) * CNT_W'(FRAME_UI);
  end

  // Lowest free countdown takes the command; none free means it is dropped.
  always_comb begin
    slot_load = '0;
    sel_done  = 1'b0;
    for (int i = 0; i < MAX_OUT; i++) begin
      if (!sel_done && !slot_busy[i]) begin
        slot_load[i] = cmd_valid;
        sel_done     = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < MAX_OUT; g++) begin : g_slot
    c2d_slot #(.CNT_W(CNT_W)) i_slot (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .load     (slot_load[g]),
      .load_val (launch_dly),
      .busy     (slot_busy[g]),
      .fire     (slot_fire[g])
    );
  end

  always_comb begin
    fire_any       = |slot_fire;
    fifo_push      = data_in_valid & ~fifo_full;
    fifo_pop       = fire_any & ~fifo_empty;
    data_out_valid = fifo_pop;
    und_set        = fire_any & fifo_empty;
    ovf_set        = data_in_valid & fifo_full;
  end

  c2d_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk   (clk),
    .rst_n (rst_n_s),
    .push  (fifo_push),
    .pop   (fifo_pop),
    .wdata (data_in),
    .rdata (data_out),
    .full  (fifo_full),
    .empty (fifo_empty),
    .count (fifo_cnt)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      err_underrun <= 1'b0;
      err_overflow <= 1'b0;
    end else begin
      if (und_set) err_underrun <= 1'b1;
      if (ovf_set) err_overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/c2d_aligner_chk.sv
module c2d_aligner_chk
  import c2d_pkg::*;
#(
  parameter  int FIFO_DEPTH = 16,
  parameter  int MAX_OUT    = 4,
  localparam int FCW        = $clog2(FIFO_DEPTH) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               data_in_valid,
  input logic               data_out_valid,
  input logic               fifo_full,
  input logic               fifo_empty,
  input logic [FCW-1:0]     fifo_cnt,
  input logic [MAX_OUT-1:0] slot_fire,
  input logic               err_underrun,
  input logic               err_overflow,
  input logic [1:0]         gran_mode,
  input logic [FRAC_W-1:0]  rnd_frac
);

  AST_FRAC_BELOW_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_frac < FRAC_W'(FRAME_UI)); // R2
  AST_TWO_UI_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (gran_mode == 2'd1) |-> !rnd_frac[0]); // R3
  AST_FRAME_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    gran_mode[1] |-> (rnd_frac == '0)); // R4
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_out_valid && !data_in_valid) |=> (fifo_cnt == $past(fifo_cnt) - FCW'(1))); // R7
  AST_SINGLE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_fire)); // R8
  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((|slot_fire) && fifo_empty) |=> err_underrun); // R9
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_underrun |=> err_underrun); // R9
  AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (data_in_valid && fifo_full) |=> err_overflow); // R10
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= FCW'(FIFO_DEPTH)); // R10

endmodule

bind c2d_aligner c2d_aligner_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .MAX_OUT    (MAX_OUT)
) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .data_in_valid  (data_in_valid),
  .data_out_valid (data_out_valid),
  .fifo_full      (fifo_full),
  .fifo_empty     (fifo_empty),
  .fifo_cnt       (fifo_cnt),
  .slot_fire      (slot_fire),
  .err_underrun   (err_underrun),
  .err_overflow   (err_overflow),
  .gran_mode      (gran_mode),
  .rnd_frac       (rnd_frac)
);

// File: tb/test_c2d_aligner.sv
`timescale 1ns/1ps
module test_c2d_aligner;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cfg_frames = '0;
  logic [3:0]  cfg_frac = 4'd1;
  logic [1:0]  cfg_extra = '0;
  logic        data_in_valid = 1'b0;
  logic [15:0] data_in = '0;
  logic        data_out_valid;
  logic [15:0] data_out;
  logic        err_underrun;
  logic        err_overflow;
  logic [7:0]  raw_ui = '0;
  logic [1:0]  gran_mode = '0;
  logic [4:0]  rnd_frames;
  logic [3:0]  rnd_frac;

  c2d_aligner i_c2d_aligner (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cfg_frames(cfg_frames), .cfg_frac(cfg_frac), .cfg_extra(cfg_extra),
    .data_in_valid(data_in_valid), .data_in(data_in),
    .data_out_valid(data_out_valid), .data_out(data_out),
    .err_underrun(err_underrun), .err_overflow(err_overflow),
    .raw_ui(raw_ui), .gran_mode(gran_mode),
    .rnd_frames(rnd_frames), .rnd_frac(rnd_frac)
  );

  always #4 clk = ~clk;

  int          n_chk = 0;
  int          n_err = 0;
  int          cyc = 0;
  int          pend[$];
  logic [15:0] mq[$];
  bit          exp_und = 1'b0;
  bit          exp_ovf = 1'b0;
  string       cur_tag = "R5";

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int cur_dly();
    return int'(cfg_frames) * 12 + int'(cfg_frac) + int'(cfg_extra) * 12;
  endfunction

  // One cycle: drive inputs, compare outputs with the model, advance the model.
  task automatic step(input bit cmd, input bit dv, input logic [15:0] din);
    bit fire;
    bit ev;
    int outst;
    int sz;
    int keep[$];
    @(negedge clk);
    cmd_valid     = cmd;
    data_in_valid = dv;
    data_in       = din;
    fire = 1'b0;
    foreach (pend[i]) if (pend[i] == cyc) fire = 1'b1;
    ev = fire && (mq.size() > 0);
    chk(data_out_valid === ev, cur_tag, "data_out_valid", int'(data_out_valid), int'(ev));
    if (ev) chk(data_out === mq[0], "R7", "data_out", int'(data_out), int'(mq[0]));
    chk(err_underrun === exp_und, "R9", "err_underrun", int'(err_underrun), int'(exp_und));
    chk(err_overflow === exp_ovf, "R10", "err_overflow", int'(err_overflow), int'(exp_ovf));
    outst = 0;
    foreach (pend[i]) if (pend[i] >= cyc) outst++;
    if (cmd && outst < 4) pend.push_back(cyc + cur_dly());
    sz = mq.size();
    if (fire && sz == 0) exp_und = 1'b1;
    if (dv && sz == 16) exp_ovf = 1'b1;
    if (ev) void'(mq.pop_front());
    if (dv && sz < 16) mq.push_back(din);
    foreach (pend[i]) if (pend[i] != cyc) keep.push_back(pend[i]);
    pend = keep;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n         = 1'b0;
    cmd_valid     = 1'b0;
    data_in_valid = 1'b0;
    pend.delete();
    mq.delete();
    exp_und = 1'b0;
    exp_ovf = 1'b0;
    #1;
    chk(data_out_valid === 1'b0, "R1", "valid in reset", int'(data_out_valid), 0);
    chk(err_underrun === 1'b0, "R1", "underrun in reset", int'(err_underrun), 0);
    chk(err_overflow === 1'b0, "R1", "overflow in reset", int'(err_overflow), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL R5 watchdog: got 0 expected 1 (run did not end)");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // Rounding helper, all raw values in every mode (R2, R3, R4).
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 256; r++) begin
        int ef;
        int er;
        string tg;
        gran_mode = m[1:0];
        raw_ui    = r[7:0];
        #1;
        ef = r / 12;
        er = r % 12;
        if (m == 1 && (er % 2) == 1) er++;
        if (er == 12) begin ef++; er = 0; end
        if (m >= 2 && er != 0) begin ef++; er = 0; end
        tg = (m == 0) ? "R2" : ((m == 1) ? "R3" : "R4");
        chk(int'(rnd_frames) == ef && int'(rnd_frac) == er, tg, "frames*16+frac",
            int'(rnd_frames) * 16 + int'(rnd_frac), ef * 16 + er);
      end
    end

    do_reset();

    // Launch timing sweep over frames, fraction and extra (R5, R6, R7).
    for (int fr = 0; fr < 4; fr++) begin
      for (int fc = 0; fc < 12; fc++) begin
        for (int ex = 0; ex < 3; ex++) begin
          int d;
          int doff;
          logic [15:0] v;
          if (fr == 0 && fc == 0 && ex == 0) continue;
          do_reset();
          cfg_frames = fr[3:0];
          cfg_frac   = fc[3:0];
          cfg_extra  = ex[1:0];
          cur_tag    = (ex == 0) ? "R5" : "R6";
          d    = cur_dly();
          doff = (fc % 2 == 1) ? d - 1 : 0;
          v    = 16'(fr * 1000 + fc * 10 + ex);
          for (int t = 0; t < d + 3; t++) step(t == 0, t == doff, v);
        end
      end
    end

    // Four outstanding, the fifth ignored, leftover beat used later (R8).
    do_reset();
    cfg_frames = 4'd2; cfg_frac = 4'd5; cfg_extra = 2'd0;
    cur_tag = "R8";
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 16'h0A00 + 16'(i));
    idle(35);
    step(1'b1, 1'b0, 16'h0);
    idle(32);

    // Early, bursty data against interleaved commands (R7).
    do_reset();
    cfg_frames = 4'd0; cfg_frac = 4'd7; cfg_extra = 2'd0;
    cur_tag = "R7";
    step(1'b0, 1'b1, 16'h00B0);
    step(1'b0, 1'b1, 16'h00B1);
    step(1'b1, 1'b0, 16'h0);
    step(1'b0, 1'b0, 16'h0);
    step(1'b1, 1'b1, 16'h00B2);
    step(1'b1, 1'b0, 16'h0);
    idle(12);

    // Launch with nothing buffered, then recovery with the flag kept (R9).
    do_reset();
    cfg_frames = 4'd0; cfg_frac = 4'd5; cfg_extra = 2'd0;
    cur_tag = "R9";
    step(1'b1, 1'b0, 16'h0);
    idle(8);
    step(1'b0, 1'b1, 16'h00C0);
    step(1'b1, 1'b0, 16'h0);
    idle(8);

    // Seventeen beats into sixteen entries, then drain (R10).
    do_reset();
    cfg_frames = 4'd0; cfg_frac = 4'd1; cfg_extra = 2'd0;
    cur_tag = "R10";
    for (int i = 0; i < 17; i++) step(1'b0, 1'b1, 16'h0D00 + 16'(i));
    for (int i = 0; i < 17; i++) step(1'b1, 1'b0, 16'h0);
    idle(4);

    // Reset with flags set, data held and a launch pending (R1).
    cfg_frames = 4'd0; cfg_frac = 4'd3; cfg_extra = 2'd0;
    cur_tag = "R1";
    step(1'b0, 1'b1, 16'h00E0);
    step(1'b0, 1'b1, 16'h00E1);
    step(1'b1, 1'b0, 16'h0);
    do_reset();
    step(1'b1, 1'b0, 16'h0);
    idle(6);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule